// File: doc/BRIEF.md
# Outbound Transaction Ordering Queue

This block sits between a memory-mapped local bus and the master side of a PCI bridge. It applies the ordering rules for traffic heading out to PCI. The local side hands over posted writes, read requests and delayed writes, meaning I/O or configuration writes. All of them enter one in-order command queue. The PCI side takes one transaction at a time through a valid/ready offer. When the transaction ends, the PCI side reports it as finished or as retried.

A read that the target retries while it is at the head of the queue leaves the queue and moves into a single parked-read slot. The queue then moves on, so later writes can go ahead of that read. The parked read is offered again when nothing at the head may go first: either the queue is empty or its head is another read. Reads never overtake one another. A read is offered only when the read-data holding register is empty, so data reaches the local bus in request order.

Back-pressure works the same way on every stream:
- Local commands: a command moves on a clock edge where `lcl_valid` and `lcl_ready` are both high.
- PCI offer: once `pci_valid` is raised, it stays high and its fields stay stable until `pci_ready` accepts it.
- Read data: once `rsp_valid` is raised, it stays high and `rsp_rdata` stays stable until `rsp_ready` takes it.

Top module: `obq_order`

## Requirements
- R1: After reset, `lcl_ready` is 1, `pci_valid` is 0 and `rsp_valid` is 0.
- R2: The type code is 2 bits: 00 posted write, 01 read, 10 delayed write. Queued commands are offered to PCI in the order they were accepted, with kind, address and write data intact.
- R3: At most one transaction is outstanding on PCI. After an offer is accepted, `pci_valid` stays low until `pci_done` or `pci_retry`.
- R4: While `pci_valid` is high and `pci_ready` is low, `pci_valid`, `pci_kind` and `pci_addr` hold their values.
- R5: A read retried at the head moves into the empty parked slot and the queue advances. Later writes are then offered ahead of it with `pci_from_slot` = 0.
- R6: A parked read is offered again with `pci_from_slot` = 1 when the queue is empty or its head is a read. A later read is never offered before the parked read has finished.
- R7: A retried posted or delayed write stays at the head and is offered again before anything later.
- R8: Read data comes out on `rsp_rdata` in request order. No read is offered while `rsp_valid` is high, and `rsp_valid`/`rsp_rdata` hold until `rsp_ready`.
- R9: A command of type 11 is accepted and discarded, and never reaches PCI.
- R10: `lcl_ready` is 0 while the queue holds DEPTH entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lcl_valid | input | 1 | Local command valid |
| lcl_ready | output | 1 | Queue can accept a command |
| lcl_kind | input | 2 | Command type |
| lcl_addr | input | AW | Command address |
| lcl_wdata | input | DW | Write data |
| pci_valid | output | 1 | Transaction offered to PCI |
| pci_ready | input | 1 | PCI accepts the offer |
| pci_kind | output | 2 | Offered type |
| pci_addr | output | AW | Offered address |
| pci_wdata | output | DW | Offered write data |
| pci_from_slot | output | 1 | Offer comes from the parked-read slot |
| pci_done | input | 1 | Outstanding transaction finished |
| pci_retry | input | 1 | Outstanding transaction retried |
| pci_rdata | input | DW | Read data, valid with `pci_done` |
| rsp_valid | output | 1 | Read data available |
| rsp_ready | input | 1 | Local side takes read data |
| rsp_rdata | output | DW | Returned read data |

## Verification
The bench builds the block with DEPTH = 4, AW = 8 and DW = 8. With this small depth, a few pushes fill the queue and reach the full boundary. The bench sweeps every ordered pair of the three legal types through the queue. It also runs the retry, park and blocked-read scenarios, comparing each offer against addresses and read data it computes itself.

// File: rtl/obq_pkg.sv
package obq_pkg;
  typedef enum logic [1:0] {
    KIND_PW  = 2'b00,
    KIND_RD  = 2'b01,
    KIND_DW  = 2'b10,
    KIND_RSV = 2'b11
  } kind_e;
endpackage

// File: rtl/obq_fifo.sv
module obq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]    mem [DEPTH];
  logic [PW-1:0]   wr_ptr, rd_ptr;
  logic [CNTW-1:0] count;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CNTW'(DEPTH));
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push && !full) wr_ptr <= bump(wr_ptr);
      if (pop && !empty) rd_ptr <= bump(rd_ptr);
      case ({push && !full, pop && !empty})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/obq_hold.sv
module obq_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set,
  input  logic [W-1:0] d,
  input  logic         clr,
  output logic         full,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      q    <= '0;
    end else if (set) begin
      full <= 1'b1;
      q    <= d;
    end else if (clr) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/obq_order.sv
module obq_order
  import obq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lcl_valid,
  output logic          lcl_ready,
  input  logic [1:0]    lcl_kind,
  input  logic [AW-1:0] lcl_addr,
  input  logic [DW-1:0] lcl_wdata,
  output logic          pci_valid,
  input  logic          pci_ready,
  output logic [1:0]    pci_kind,
  output logic [AW-1:0] pci_addr,
  output logic [DW-1:0] pci_wdata,
  output logic          pci_from_slot,
  input  logic          pci_done,
  input  logic          pci_retry,
  input  logic [DW-1:0] pci_rdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata
);
  localparam int CW = 2 + AW + DW;

  logic [CW-1:0] in_cmd, head_cmd, slot_cmd, out_cmd;
  logic          q_empty, q_full, q_push, q_pop;
  logic          slot_occ, slot_set, slot_clr;
  logic          rsp_set;
  logic          busy, src_slot, cur_rd, hold_slot;
  logic          head_wr, pick_head, pick_slot, sel_slot, issue;
  logic [1:0]    head_kind;

  assign in_cmd    = {lcl_kind, lcl_addr, lcl_wdata};
  assign lcl_ready = !q_full;
  assign q_push    = lcl_valid && !q_full && (lcl_kind != KIND_RSV);

  obq_fifo #(.W(CW), .DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(q_push), .din(in_cmd), .pop(q_pop),
    .head(head_cmd), .empty(q_empty), .full(q_full)
  );

  obq_hold #(.W(CW)) u_park (
    .clk(clk), .rst_n(rst_n), .set(slot_set), .d(head_cmd), .clr(slot_clr),
    .full(slot_occ), .q(slot_cmd)
  );

  obq_hold #(.W(DW)) u_rbuf (
    .clk(clk), .rst_n(rst_n), .set(rsp_set), .d(pci_rdata),
    .clr(rsp_valid && rsp_ready), .full(rsp_valid), .q(rsp_rdata)
  );

  // Arbitration: writes at the head may overtake a parked read; reads wait
  // for an empty data register and never overtake the parked read.
  assign head_kind = head_cmd[CW-1 -: 2];
  assign head_wr   = !q_empty && (head_kind != KIND_RD);
  assign pick_head = !q_empty && (head_wr || (!slot_occ && !rsp_valid));
  assign pick_slot = slot_occ && !rsp_valid && !head_wr;
  assign sel_slot  = hold_slot || pick_slot;

  assign pci_valid     = !busy && (hold_slot || pick_head || pick_slot);
  assign out_cmd       = sel_slot ? slot_cmd : head_cmd;
  assign pci_kind      = out_cmd[CW-1 -: 2];
  assign pci_addr      = out_cmd[DW +: AW];
  assign pci_wdata     = out_cmd[DW-1:0];
  assign pci_from_slot = sel_slot;
  assign issue         = pci_valid && pci_ready;

  // Completion handling for the single outstanding transaction.
  assign slot_set = busy && !src_slot && pci_retry && cur_rd && !slot_occ;
  assign slot_clr = busy && src_slot && pci_done;
  assign q_pop    = (busy && !src_slot && pci_done) || slot_set;
  assign rsp_set  = busy && pci_done && cur_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      src_slot  <= 1'b0;
      cur_rd    <= 1'b0;
      hold_slot <= 1'b0;
    end else begin
      if (issue) begin
        busy     <= 1'b1;
        src_slot <= sel_slot;
        cur_rd   <= (pci_kind == KIND_RD);
      end else if (busy && (pci_done || pci_retry)) begin
        busy <= 1'b0;
      end
      hold_slot <= pci_valid && !pci_ready && sel_slot;
    end
  end
endmodule

// File: rtl/obq_order_chk.sv
module obq_order_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pci_valid,
  input logic          pci_ready,
  input logic [1:0]    pci_kind,
  input logic [AW-1:0] pci_addr,
  input logic          pci_from_slot,
  input logic          pci_done,
  input logic          pci_retry,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_rdata
);
  logic outst;
  always_ff @(posedge clk) begin
    if (!rst_n) outst <= 1'b0;
    else if (pci_valid && pci_ready) outst <= 1'b1;
    else if (pci_done || pci_retry) outst <= 1'b0;
  end

  a_r3_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    pci_valid |-> !outst);

  a_r4_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
    pci_valid && !pci_ready |=> pci_valid && $stable(pci_kind) && $stable(pci_addr));

  a_r6_slot_is_read: assert property (@(posedge clk) disable iff (!rst_n)
    pci_valid && pci_from_slot |-> pci_kind == 2'b01);

  a_r8_no_read_with_data: assert property (@(posedge clk) disable iff (!rst_n)
    pci_valid && pci_kind == 2'b01 |-> !rsp_valid);

  a_r8_rsp_held: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  a_r9_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    pci_valid |-> pci_kind != 2'b11);
endmodule

bind obq_order obq_order_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/test_obq_order.sv
module test_obq_order;
  localparam int DEPTH = 4;
  localparam int AW = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lcl_valid = 1'b0, lcl_ready;
  logic [1:0]    lcl_kind = '0;
  logic [AW-1:0] lcl_addr = '0;
  logic [DW-1:0] lcl_wdata = '0;
  logic          pci_valid, pci_ready = 1'b0;
  logic [1:0]    pci_kind;
  logic [AW-1:0] pci_addr;
  logic [DW-1:0] pci_wdata;
  logic          pci_from_slot;
  logic          pci_done = 1'b0, pci_retry = 1'b0;
  logic [DW-1:0] pci_rdata = '0;
  logic          rsp_valid, rsp_ready = 1'b0;
  logic [DW-1:0] rsp_rdata;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  obq_order #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_obq_order (.*);

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      checks = checks + 1;
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected under 20000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] k, input logic [AW-1:0] a);
    @(negedge clk);
    lcl_valid = 1'b1; lcl_kind = k; lcl_addr = a; lcl_wdata = a + 8'd1;
    while (!lcl_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    lcl_valid = 1'b0;
  endtask

  // Wait for an offer, compare it, accept, then finish or retry it.
  task automatic serve(input logic [1:0] k, input logic [AW-1:0] a,
                       input logic slot, input logic rty, input string tag);
    while (!pci_valid) @(negedge clk);
    chk(pci_kind == k && pci_addr == a && pci_from_slot == slot &&
        (k == 2'b01 || pci_wdata == a + 8'd1), tag,
        {pci_from_slot, pci_kind, pci_addr}, {slot, k, a});
    pci_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    pci_ready = 1'b0;
    chk(!pci_valid, {tag, " R3 quiet while outstanding"}, pci_valid, 0);
    pci_done = !rty; pci_retry = rty; pci_rdata = a ^ 8'hA5;
    @(posedge clk);
    @(negedge clk);
    pci_done = 1'b0; pci_retry = 1'b0;
  endtask

  task automatic get_rsp(input logic [AW-1:0] a, input string tag);
    while (!rsp_valid) @(negedge clk);
    chk(rsp_rdata == (a ^ 8'hA5), tag, rsp_rdata, a ^ 8'hA5);
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(lcl_ready && !pci_valid && !rsp_valid, "R1 reset state",
        {lcl_ready, pci_valid, rsp_valid}, 3'b100);

    // R2: sweep all ordered pairs of legal kinds
    for (int i = 0; i < 9; i++) begin
      logic [1:0] k1, k2;
      logic [AW-1:0] a1, a2;
      k1 = 2'(i / 3); k2 = 2'(i % 3);
      a1 = 8'h10 + 8'(4 * i); a2 = a1 + 8'd2;
      push(k1, a1);
      push(k2, a2);
      serve(k1, a1, 1'b0, 1'b0, "R2 sweep first");
      if (k1 == 2'b01) get_rsp(a1, "R8 sweep data first");
      serve(k2, a2, 1'b0, 1'b0, "R2 sweep second");
      if (k2 == 2'b01) get_rsp(a2, "R8 sweep data second");
    end

    // R4: offer held under back-pressure
    push(2'b10, 8'h70);
    while (!pci_valid) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(pci_valid && pci_addr == 8'h70, "R4 offer held", pci_addr, 8'h70);
    serve(2'b10, 8'h70, 1'b0, 1'b0, "R4 held offer taken");

    // R5/R6: retried read parks, writes overtake it
    push(2'b01, 8'h80);
    push(2'b00, 8'h81);
    push(2'b00, 8'h82);
    serve(2'b01, 8'h80, 1'b0, 1'b1, "R5 read retried");
    serve(2'b00, 8'h81, 1'b0, 1'b0, "R5 write overtakes");
    serve(2'b00, 8'h82, 1'b0, 1'b0, "R5 second write overtakes");
    serve(2'b01, 8'h80, 1'b1, 1'b0, "R6 parked read reissued");
    get_rsp(8'h80, "R8 parked read data");

    // R6: later read waits for parked read
    push(2'b01, 8'h90);
    push(2'b01, 8'h91);
    push(2'b00, 8'h92);
    serve(2'b01, 8'h90, 1'b0, 1'b1, "R6 first read retried");
    serve(2'b01, 8'h90, 1'b1, 1'b0, "R6 parked read before later read");
    chk(!pci_valid, "R8 no read while data pending", pci_valid, 0);
    get_rsp(8'h90, "R8 first read data");
    serve(2'b01, 8'h91, 1'b0, 1'b0, "R6 later read after parked");
    get_rsp(8'h91, "R8 second read data");
    serve(2'b00, 8'h92, 1'b0, 1'b0, "R6 write after reads");

    // R8: pending data blocks the next read
    push(2'b01, 8'hA0);
    push(2'b01, 8'hA1);
    serve(2'b01, 8'hA0, 1'b0, 1'b0, "R8 read one");
    repeat (3) @(negedge clk);
    chk(!pci_valid && rsp_valid, "R8 data held, next read waits",
        {pci_valid, rsp_valid}, 2'b01);
    get_rsp(8'hA0, "R8 data order one");
    serve(2'b01, 8'hA1, 1'b0, 1'b0, "R8 read two");
    get_rsp(8'hA1, "R8 data order two");

    // R7: retried delayed write stays at head
    push(2'b10, 8'hB0);
    push(2'b00, 8'hB1);
    serve(2'b10, 8'hB0, 1'b0, 1'b1, "R7 delayed write retried");
    serve(2'b10, 8'hB0, 1'b0, 1'b0, "R7 delayed write reissued");
    serve(2'b00, 8'hB1, 1'b0, 1'b0, "R7 posted write after");

    // R9: reserved type discarded
    push(2'b11, 8'hC0);
    push(2'b00, 8'hC1);
    serve(2'b00, 8'hC1, 1'b0, 1'b0, "R9 reserved skipped");
    repeat (2) @(negedge clk);
    chk(!pci_valid, "R9 nothing left", pci_valid, 0);

    // R10: full queue
    for (int i = 0; i < DEPTH; i++) push(2'b00, 8'hD0 + 8'(i));
    chk(!lcl_ready, "R10 ready low when full", lcl_ready, 0);
    for (int i = 0; i < DEPTH; i++) serve(2'b00, 8'hD0 + 8'(i), 1'b0, 1'b0, "R10 drain order");
    chk(lcl_ready, "R10 ready back", lcl_ready, 1);

    summary();
  end
endmodule